// File: doc/BRIEF.md
# Three-Input Bitwise Truth-Table Vector Unit

This unit computes any Boolean function of three inputs on every bit of three packed vector operands. An 8-bit truth-table immediate selects the function. At each bit position the three operand bits form a 3-bit index, and the result bit is the immediate bit at that index. The first operand also carries the old contents of the destination register. That old value is what merge masking keeps in elements whose mask bit is clear.

The vector is built from 32-bit chunks. An element is either one chunk (32-bit mode) or two adjacent chunks (64-bit mode). A per-element write mask chooses which elements take the computed value. Elements that are not written are either kept (merge) or cleared (zero). An unmasked form writes every element. A length code selects a quarter, half or all of the full width, and every bit above the selected length is cleared. The result is registered once and comes with a valid strobe.

Top module: `bf3_vec_unit`

## Requirements
- R1: Each result bit equals `func_imm[{a,b,c}]`. The bit of `vec_a` is the most significant index bit, the bit of `vec_b` is the middle bit and the bit of `vec_c` is the least significant bit.
- R2: With every element written, immediate 0xF0 returns `vec_a`, 0xCC returns `vec_b` and 0xAA returns `vec_c`.
- R3: With every element written, immediate 0x96 returns the three-way XOR and 0xE8 returns the bitwise majority of the operands.
- R4: When `use_mask`=1, element n is written with the computed value when `wr_mask[n]`=1. In 32-bit mode (`elem64`=0), element n is bits [32n+31:32n] and all 16 mask bits are used. In 64-bit mode (`elem64`=1), element n is bits [64n+63:64n] and only mask bits 7..0 are used; bits 15..8 are ignored.
- R5: In merge mode (`zero_fill`=0), a masked-off element keeps the old value, which is the same element of `vec_a`.
- R6: In zero mode (`zero_fill`=1), a masked-off element becomes zero.
- R7: When `use_mask`=0, every element inside the length is written with the computed value, whatever `wr_mask` and `zero_fill` hold.
- R8: `vlen_sel` 0 selects the low quarter of the width (128 bits), 1 selects the low half (256 bits), and 2 or 3 select the full width (512 bits). Every bit of `res_vec` above the selected length is zero.
- R9: `res_valid` is high in the cycle after a cycle with `op_valid` high, and `res_vec` carries that operation's result in the same cycle.
- R10: While `op_valid` is low, `res_vec` holds its last value and `res_valid` is low.
- R11: While `rst_n` is low, `res_valid` is 0 and `res_vec` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| func_imm | input | 8 | Truth-table immediate |
| elem64 | input | 1 | 1 = 64-bit elements, 0 = 32-bit elements |
| vlen_sel | input | 2 | Vector length code |
| use_mask | input | 1 | 1 = apply the write mask, 0 = write all elements |
| zero_fill | input | 1 | 1 = clear masked-off elements, 0 = keep them |
| wr_mask | input | 16 | Per-element write mask |
| vec_a | input | 512 | First operand and old destination value |
| vec_b | input | 512 | Second operand |
| vec_c | input | 512 | Third operand |
| res_valid | output | 1 | Result strobe |
| res_vec | output | 512 | New destination value |

## Verification
The bench targets the index order. A design that swaps operand positions produces the wrong operand for 0xCC or 0xAA and a wrong asymmetric function such as 0xD8. It checks that 64-bit mode maps mask bit n onto a chunk pair and ignores the upper mask byte; a design that uses chunk indices writes the wrong halves. It tests merge against zero fill, whether masking stays off in the unmasked form even when zero fill is set and the mask is empty, and whether bits above a short vector length are cleared rather than merged from `vec_a`. It also checks that the result register holds its value and drops the strobe while no operation is presented.

// File: rtl/bf3_pkg.sv
package bf3_pkg;
  localparam int CHUNK_W = 32;

  typedef enum logic [1:0] {
    VL_QUARTER = 2'd0,
    VL_HALF    = 2'd1,
    VL_FULL    = 2'd2,
    VL_FULL_X  = 2'd3
  } vlen_e;

  // number of live 32-bit chunks for a length code
  function automatic int unsigned live_chunks(input logic [1:0] code, input int unsigned nchunk);
    case (code)
      VL_QUARTER: live_chunks = nchunk / 4;
      VL_HALF:    live_chunks = nchunk / 2;
      default:    live_chunks = nchunk;
    endcase
  endfunction
endpackage

// File: rtl/bf3_eval.sv
module bf3_eval #(
  parameter int W = 512
) (
  input  logic [7:0]   func_imm,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] y
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [2:0] sel;
    assign sel  = {a[i], b[i], c[i]};
    assign y[i] = func_imm[sel];
  end
endmodule

// File: rtl/bf3_wmask.sv
module bf3_wmask
  import bf3_pkg::*;
#(
  parameter int NCHUNK = 16,
  parameter int MASK_W = 16
) (
  input  logic              elem64,
  input  logic [1:0]        vlen_sel,
  input  logic              use_mask,
  input  logic [MASK_W-1:0] wr_mask,
  output logic [NCHUNK-1:0] chunk_wr,
  output logic [NCHUNK-1:0] chunk_live
);
  localparam int LIM_W = $clog2(NCHUNK) + 1;

  logic [LIM_W-1:0] limit;

  always_comb begin
    limit = LIM_W'(live_chunks(vlen_sel, NCHUNK));
  end

  for (genvar j = 0; j < NCHUNK; j++) begin : g_chunk
    localparam int IDX32 = j % MASK_W;
    localparam int IDX64 = (j / 2) % MASK_W;
    logic mbit;
    always_comb begin
      mbit = elem64 ? wr_mask[IDX64] : wr_mask[IDX32];
    end
    assign chunk_wr[j]   = ~use_mask | mbit;
    assign chunk_live[j] = (LIM_W'(j) < limit);
  end
endmodule

// File: rtl/bf3_merge.sv
module bf3_merge #(
  parameter int NCHUNK  = 16,
  parameter int CHUNK_W = 32
) (
  input  logic [NCHUNK*CHUNK_W-1:0] computed,
  input  logic [NCHUNK*CHUNK_W-1:0] old_val,
  input  logic [NCHUNK-1:0]         chunk_wr,
  input  logic [NCHUNK-1:0]         chunk_live,
  input  logic                      zero_fill,
  output logic [NCHUNK*CHUNK_W-1:0] merged
);
  for (genvar j = 0; j < NCHUNK; j++) begin : g_sel
    always_comb begin
      if (!chunk_live[j]) begin
        merged[j*CHUNK_W +: CHUNK_W] = '0;
      end else if (chunk_wr[j]) begin
        merged[j*CHUNK_W +: CHUNK_W] = computed[j*CHUNK_W +: CHUNK_W];
      end else if (zero_fill) begin
        merged[j*CHUNK_W +: CHUNK_W] = '0;
      end else begin
        merged[j*CHUNK_W +: CHUNK_W] = old_val[j*CHUNK_W +: CHUNK_W];
      end
    end
  end
endmodule

// File: rtl/bf3_vec_unit.sv
module bf3_vec_unit
  import bf3_pkg::*;
#(
  parameter int VEC_W = 512
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   op_valid,
  input  logic [7:0]             func_imm,
  input  logic                   elem64,
  input  logic [1:0]             vlen_sel,
  input  logic                   use_mask,
  input  logic                   zero_fill,
  input  logic [VEC_W/32-1:0]    wr_mask,
  input  logic [VEC_W-1:0]       vec_a,
  input  logic [VEC_W-1:0]       vec_b,
  input  logic [VEC_W-1:0]       vec_c,
  output logic                   res_valid,
  output logic [VEC_W-1:0]       res_vec
);
  localparam int NCHUNK = VEC_W / CHUNK_W;

  logic [VEC_W-1:0]  computed;
  logic [VEC_W-1:0]  merged;
  logic [NCHUNK-1:0] chunk_wr;
  logic [NCHUNK-1:0] chunk_live;

  logic              valid_d, valid_q;
  logic [VEC_W-1:0]  vec_d, vec_q;
  logic              vec_en;

  bf3_eval #(.W(VEC_W)) u_eval (
    .func_imm (func_imm),
    .a        (vec_a),
    .b        (vec_b),
    .c        (vec_c),
    .y        (computed)
  );

  bf3_wmask #(.NCHUNK(NCHUNK), .MASK_W(NCHUNK)) u_wmask (
    .elem64     (elem64),
    .vlen_sel   (vlen_sel),
    .use_mask   (use_mask),
    .wr_mask    (wr_mask),
    .chunk_wr   (chunk_wr),
    .chunk_live (chunk_live)
  );

  bf3_merge #(.NCHUNK(NCHUNK), .CHUNK_W(CHUNK_W)) u_merge (
    .computed   (computed),
    .old_val    (vec_a),
    .chunk_wr   (chunk_wr),
    .chunk_live (chunk_live),
    .zero_fill  (zero_fill),
    .merged     (merged)
  );

  // next state
  always_comb begin
    valid_d = op_valid;
    vec_en  = op_valid;
    vec_d   = merged;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
    end else if (vec_en) begin
      vec_q <= vec_d;
    end
  end

  assign res_valid = valid_q;
  assign res_vec   = vec_q;
endmodule

// File: rtl/bf3_vec_unit_chk.sv
module bf3_vec_unit_chk #(
  parameter int VEC_W = 512
) (
  input logic                clk,
  input logic                rst_n,
  input logic                op_valid,
  input logic [7:0]          func_imm,
  input logic [1:0]          vlen_sel,
  input logic                use_mask,
  input logic                zero_fill,
  input logic [VEC_W/32-1:0] wr_mask,
  input logic [VEC_W-1:0]    vec_a,
  input logic                res_valid,
  input logic [VEC_W-1:0]    res_vec
);
  // R9
  strobe_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);

  // R10
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !res_valid);

  // R10
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(res_vec));

  // R8
  quarter_upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && vlen_sel == 2'd0) |=> (res_vec[VEC_W-1:VEC_W/4] == '0));

  // R6
  zero_empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && use_mask && zero_fill && wr_mask == '0) |=> (res_vec == '0));

  // R2
  pass_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !use_mask && vlen_sel[1] && func_imm == 8'hF0) |=> (res_vec == $past(vec_a)));

  // R11
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_state_chk: assert (!res_valid && res_vec == '0);
    end
  end
endmodule

bind bf3_vec_unit bf3_vec_unit_chk #(.VEC_W(VEC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .func_imm  (func_imm),
  .vlen_sel  (vlen_sel),
  .use_mask  (use_mask),
  .zero_fill (zero_fill),
  .wr_mask   (wr_mask),
  .vec_a     (vec_a),
  .res_valid (res_valid),
  .res_vec   (res_vec)
);

// File: tb/test_bf3_vec_unit.sv
module test_bf3_vec_unit;
  localparam int VW = 512;
  localparam int NC = VW / 32;

  typedef struct packed {
    logic [7:0]  tt;
    logic        e64;
    logic [1:0]  vl;
    logic        msk;
    logic        zm;
    logic [15:0] mask;
    logic [31:0] sa;
    logic [31:0] sb;
    logic [31:0] sc;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{8'hF0, 1'b0, 2'd2, 1'b0, 1'b0, 16'h0000, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0F0F_3C3C}, // R2 a
    '{8'hCC, 1'b0, 2'd2, 1'b0, 1'b0, 16'h0000, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0F0F_3C3C}, // R2 b
    '{8'hAA, 1'b0, 2'd2, 1'b0, 1'b0, 16'h0000, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0F0F_3C3C}, // R2 c
    '{8'h96, 1'b0, 2'd2, 1'b0, 1'b0, 16'h0000, 32'hDEAD_BEEF, 32'h5555_AAAA, 32'h00FF_F00F}, // R3 xor
    '{8'hE8, 1'b0, 2'd3, 1'b0, 1'b0, 16'h0000, 32'hDEAD_BEEF, 32'h5555_AAAA, 32'h00FF_F00F}, // R3 majority
    '{8'hD8, 1'b0, 2'd2, 1'b1, 1'b0, 16'hA5C3, 32'hF0F0_0F0F, 32'h3333_CCCC, 32'h6969_9696}, // R1 R4 R5
    '{8'h6A, 1'b0, 2'd2, 1'b1, 1'b1, 16'h3C0F, 32'hCAFE_F00D, 32'h1357_9BDF, 32'h2468_ACE0}, // R1 R6
    '{8'h1E, 1'b1, 2'd2, 1'b1, 1'b0, 16'hFF96, 32'h0123_4567, 32'h89AB_CDEF, 32'hFEDC_BA98}, // R4 64-bit
    '{8'h78, 1'b1, 2'd1, 1'b1, 1'b1, 16'h005A, 32'hA5A5_5A5A, 32'hFFFF_0000, 32'h7777_8888}, // R6 R8
    '{8'h96, 1'b0, 2'd0, 1'b0, 1'b0, 16'hFFFF, 32'hBEEF_CAFE, 32'h0BAD_F00D, 32'h1111_2222}, // R8 quarter
    '{8'hE8, 1'b0, 2'd2, 1'b0, 1'b1, 16'h0000, 32'h8421_8421, 32'h4812_4812, 32'h2184_2184}, // R7
    '{8'h01, 1'b0, 2'd1, 1'b1, 1'b0, 16'hFFFF, 32'hFFFF_FFFF, 32'h0000_0001, 32'h8000_0000}  // R8 half
  };

  logic          clk, rst_n, op_valid, elem64, use_mask, zero_fill;
  logic [7:0]    func_imm;
  logic [1:0]    vlen_sel;
  logic [15:0]   wr_mask;
  logic [VW-1:0] vec_a, vec_b, vec_c, res_vec;
  logic          res_valid;

  int  checks = 0;
  int  failures = 0;
  bit  finished = 0;

  bf3_vec_unit i_bf3_vec_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .func_imm(func_imm),
    .elem64(elem64), .vlen_sel(vlen_sel), .use_mask(use_mask), .zero_fill(zero_fill),
    .wr_mask(wr_mask), .vec_a(vec_a), .vec_b(vec_b), .vec_c(vec_c),
    .res_valid(res_valid), .res_vec(res_vec)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [VW-1:0] spread(input logic [31:0] s);
    logic [VW-1:0] v;
    for (int j = 0; j < NC; j++) v[j*32 +: 32] = s + 32'(j) * 32'h1111_1111;
    return v;
  endfunction

  function automatic logic [VW-1:0] model(input vec_t t, input logic [VW-1:0] a,
                                          input logic [VW-1:0] b, input logic [VW-1:0] c);
    logic [VW-1:0] r;
    int nc;
    nc = (t.vl == 2'd0) ? NC / 4 : (t.vl == 2'd1) ? NC / 2 : NC;
    for (int j = 0; j < NC; j++) begin
      logic mb;
      mb = t.e64 ? t.mask[j / 2] : t.mask[j];
      for (int k = 0; k < 32; k++) begin
        int p;
        logic f;
        p = j * 32 + k;
        f = t.tt[{a[p], b[p], c[p]}];
        if (j >= nc)              r[p] = 1'b0;
        else if (!t.msk || mb)    r[p] = f;
        else if (t.zm)            r[p] = 1'b0;
        else                      r[p] = a[p];
      end
    end
    return r;
  endfunction

  task automatic check_vec(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t t);
    @(negedge clk);
    op_valid  = 1'b1;
    func_imm  = t.tt;
    elem64    = t.e64;
    vlen_sel  = t.vl;
    use_mask  = t.msk;
    zero_fill = t.zm;
    wr_mask   = t.mask;
    vec_a     = spread(t.sa);
    vec_b     = spread(t.sb);
    vec_c     = spread(t.sc);
    @(negedge clk);
    op_valid  = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    logic [VW-1:0] exp_v, held;
    rst_n = 1'b0; op_valid = 1'b0; func_imm = '0; elem64 = 1'b0; vlen_sel = '0;
    use_mask = 1'b0; zero_fill = 1'b0; wr_mask = '0; vec_a = '0; vec_b = '0; vec_c = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check_bit("R11 valid", res_valid, 1'b0);
    check_vec("R11 vec", res_vec, '0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      exp_v = model(TBL[i], spread(TBL[i].sa), spread(TBL[i].sb), spread(TBL[i].sc));
      check_bit("R9 strobe", res_valid, 1'b1);
      check_vec($sformatf("R1 R4 R5 R6 R7 R8 vector %0d", i), res_vec, exp_v);
    end

    // R2 direct operand identities against the operands themselves
    drive(TBL[1]);
    check_vec("R2 0xCC is b", res_vec, spread(TBL[1].sb));
    drive(TBL[2]);
    check_vec("R2 0xAA is c", res_vec, spread(TBL[2].sc));
    // R3 xor and majority from their definitions
    drive(TBL[3]);
    check_vec("R3 xor", res_vec, spread(TBL[3].sa) ^ spread(TBL[3].sb) ^ spread(TBL[3].sc));
    drive(TBL[4]);
    exp_v = (spread(TBL[4].sa) & spread(TBL[4].sb)) | (spread(TBL[4].sa) & spread(TBL[4].sc))
          | (spread(TBL[4].sb) & spread(TBL[4].sc));
    check_vec("R3 majority", res_vec, exp_v);

    // R10 idle: inputs change with op_valid low
    held = res_vec;
    @(negedge clk);
    vec_a = ~vec_a; vec_b = ~vec_b; func_imm = 8'h55;
    @(negedge clk);
    @(negedge clk);
    check_bit("R10 strobe low", res_valid, 1'b0);
    check_vec("R10 held", res_vec, held);

    // R11 reset in mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check_bit("R11 valid again", res_valid, 1'b0);
    check_vec("R11 vec again", res_vec, '0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule